// File: doc/BRIEF.md
# Jitter Attenuator Elastic Buffer

This block is a bit-serial elastic store for a line interface. Bits arrive on a jittery write clock and leave on a smoothed read clock that an external loop produces. The store sits on either the transmit or the receive data path, or is switched out so that both paths pass straight through. The read clock also clocks a seven-bit control word that selects the active depth, the path, enable, recentring and clear.

A running store holds about half its depth. Any change of the centre bit, in either direction, places the read pointer half a depth behind the synchronised write pointer. An underflow or an overflow also recentres, and it sets a sticky slip flag. Clear holds both pointers and the status at their idle values but leaves the stored bits in place. A new depth value is applied only when a recentre or a clear happens, so the fill level is never judged against a depth that the pointers were not set up for.

Top module: `jitter_elastic_store`

## Requirements
- R1: After reset, every control bit is 0, the empty flag is 1, and the full, half and slip flags are 0.
- R2: While the enable bit (control bit 0) is 0, txOut equals txIn and rxOut equals rxIn in the same cycle.
- R3: While enabled, a path bit (control bit 1) of 1 routes the transmit data through the store and passes the receive data straight through. A path bit of 0 does the reverse.
- R4: The depth field (control bits 5:3, value n) selects (n+1)*16 words. With equal read and write rates, after a recentre a bit written at sample k appears at the output between h and h+6 samples later, where h is half the depth.
- R5: A change of the centre bit (control bit 2) from 0 to 1 or from 1 to 0 recentres the read pointer to half the active depth behind the synchronised write pointer.
- R6: A new depth value written without a recentre or a clear leaves the latency at its previous value.
- R7: While the clear bit (control bit 6) is 1, the flags read empty, not full and no slip. After clear is released, no read and no slip happen until a recentre.
- R8: Clear does not alter the stored bits; a recentre after clear reads back the bits written before it.
- R9: Reading while empty recentres the store and sets the slip flag, which then stays set until clear. A store running at matched rates never sets it.
- R10: When the fill level reaches the active depth, the full flag rises, the store recentres and the slip flag is set.
- R11: At matched rates after a recentre, the half flag is 1 and the full and empty flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Jittery write clock |
| rdClk | input | 1 | Smoothed read clock; also clocks the control word |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| cfgWrite | input | 1 | Loads cfgData into the control word (rdClk domain) |
| cfgData | input | 7 | Control word: enable, path, centre, depth[2:0], clear |
| txIn | input | 1 | Transmit data in (wrClk domain) |
| rxIn | input | 1 | Receive data in (wrClk domain) |
| txOut | output | 1 | Transmit data out |
| rxOut | output | 1 | Receive data out |
| stEmpty | output | 1 | Fill level is zero, or clear is active |
| stFull | output | 1 | Fill level has reached the active depth |
| stHalf | output | 1 | Fill level is at least half the active depth |
| stSlip | output | 1 | Sticky: an underflow or overflow has occurred |

## Verification
The assertions assume that the write clock never runs faster than twice the read clock. Under that assumption the synchronised write pointer moves by at most two per read cycle, so the fill level just after a recentre lies within two words of half the depth. The bench keeps to this: the two clocks share a 4 ns period at a fixed phase offset, and only for the overflow case is the read period doubled. The write clock is gated only while its input low phase is in progress, so a gated clock never produces a short pulse.

// File: rtl/jes_pkg.sv
package jes_pkg;
  localparam int unsigned STEP_WORDS  = 16;
  localparam int unsigned STEP_BITS   = $clog2(STEP_WORDS);
  localparam int unsigned SEL_W       = 3;
  localparam int unsigned MAX_WORDS   = STEP_WORDS << SEL_W;
  localparam int unsigned ADDR_W      = $clog2(MAX_WORDS);
  localparam int unsigned PTR_W       = ADDR_W + 1;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned CFG_W       = 7;

  // control word bit positions
  localparam int unsigned CFG_EN  = 0;
  localparam int unsigned CFG_TX  = 1;
  localparam int unsigned CFG_CTR = 2;
  localparam int unsigned CFG_DEP = 3;
  localparam int unsigned CFG_CLR = 6;

  typedef logic [PTR_W-1:0] ptr_t;

  typedef struct packed {
    logic en;
    logic pathTx;
    logic clear;
    logic recentre;
    logic advance;
    ptr_t halfDepth;
  } strobe_t;

  function automatic ptr_t depthWords(logic [SEL_W-1:0] sel);
    return ptr_t'((32'(sel) + 32'd1) * STEP_WORDS);
  endfunction

  function automatic ptr_t bin2gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray2bin(ptr_t g);
    ptr_t b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/jes_ctrl.sv
module jes_ctrl
  import jes_pkg::*;
(
  input  logic             rdClk,
  input  logic             rstN,
  input  logic             cfgWrite,
  input  logic [CFG_W-1:0] cfgData,
  input  ptr_t             fill,
  output strobe_t          strb,
  output logic             stEmpty,
  output logic             stFull,
  output logic             stHalf,
  output logic             stSlip
);
  logic enReg, txReg, ctrReg, ctrPrev, clrReg, primed;
  logic [SEL_W-1:0] depSel;
  ptr_t activeDepth, newDepth;
  logic toggle, isEmpty, isFull, underflow, overflow, recentre, advance;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      enReg  <= 1'b0;
      txReg  <= 1'b0;
      ctrReg <= 1'b0;
      clrReg <= 1'b0;
      depSel <= '0;
    end else if (cfgWrite) begin
      enReg  <= cfgData[CFG_EN];
      txReg  <= cfgData[CFG_TX];
      ctrReg <= cfgData[CFG_CTR];
      clrReg <= cfgData[CFG_CLR];
      depSel <= cfgData[CFG_DEP +: SEL_W];
    end
  end

  always_comb begin
    newDepth  = depthWords(depSel);
    toggle    = ctrReg ^ ctrPrev;
    isEmpty   = (fill == '0);
    isFull    = (fill >= activeDepth);
    underflow = enReg && !clrReg && primed && isEmpty;
    overflow  = enReg && !clrReg && primed && isFull;
    recentre  = enReg && !clrReg && (toggle || underflow || overflow);
    advance   = enReg && !clrReg && primed && !isEmpty && !recentre;
    strb.en        = enReg;
    strb.pathTx    = txReg;
    strb.clear     = clrReg;
    strb.recentre  = recentre;
    strb.advance   = advance;
    strb.halfDepth = newDepth >> 1;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      ctrPrev     <= 1'b0;
      primed      <= 1'b0;
      stSlip      <= 1'b0;
      activeDepth <= depthWords('0);
    end else begin
      ctrPrev <= ctrReg;
      if (clrReg) begin
        primed      <= 1'b0;
        stSlip      <= 1'b0;
        activeDepth <= newDepth;
      end else begin
        if (recentre) begin
          primed      <= 1'b1;
          activeDepth <= newDepth;
        end
        if (underflow || overflow) stSlip <= 1'b1;
      end
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      stEmpty <= 1'b1;
      stFull  <= 1'b0;
      stHalf  <= 1'b0;
    end else begin
      stEmpty <= clrReg || isEmpty;
      stFull  <= !clrReg && isFull;
      stHalf  <= !clrReg && (fill >= (activeDepth >> 1));
    end
  end

  // R7
  clear_status_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    clrReg |=> (stEmpty && !stFull && !stSlip));

  // R9
  slip_hold_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (stSlip && !clrReg) |=> stSlip);

  // R6
  depth_hold_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (!clrReg && !recentre) |=> $stable(activeDepth));

  // R4
  depth_step_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (activeDepth[STEP_BITS-1:0] == '0) && (activeDepth != '0)
      && (activeDepth <= ptr_t'(MAX_WORDS)));

  // R10
  no_full_empty_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    !(stEmpty && stFull));
endmodule

// File: rtl/jes_datapath.sv
module jes_datapath
  import jes_pkg::*;
(
  input  logic    wrClk,
  input  logic    rdClk,
  input  logic    rstN,
  input  strobe_t strb,
  input  logic    txIn,
  input  logic    rxIn,
  output logic    txOut,
  output logic    rxOut,
  output ptr_t    fill
);
  logic wrArstN, wrData, bufOut;
  logic [SYNC_STAGES-1:0] wrGo;
  ptr_t wrPtr, wrGray, wrBinRd, rdPtr;
  ptr_t graySync [SYNC_STAGES];
  logic mem [MAX_WORDS];

  // clear holds the write side in reset; release is synchronised by wrGo
  assign wrArstN = rstN & ~strb.clear;
  assign wrData  = strb.pathTx ? txIn : rxIn;

  always_ff @(posedge wrClk or negedge wrArstN) begin
    if (!wrArstN) begin
      wrGo   <= '0;
      wrPtr  <= '0;
      wrGray <= '0;
    end else begin
      wrGo <= {wrGo[SYNC_STAGES-2:0], strb.en};
      if (wrGo[SYNC_STAGES-1]) begin
        wrPtr  <= wrPtr + 1'b1;
        wrGray <= bin2gray(wrPtr + 1'b1);
      end
    end
  end

  // storage has no reset: clear leaves contents in place
  always_ff @(posedge wrClk) begin
    if (wrGo[SYNC_STAGES-1]) mem[wrPtr[ADDR_W-1:0]] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) graySync[s] <= '0;
    end else begin
      graySync[0] <= wrGray;
      for (int s = 1; s < SYNC_STAGES; s++) graySync[s] <= graySync[s-1];
    end
  end

  assign wrBinRd = gray2bin(graySync[SYNC_STAGES-1]);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)              rdPtr <= '0;
    else if (strb.clear)    rdPtr <= '0;
    else if (strb.recentre) rdPtr <= wrBinRd - strb.halfDepth;
    else if (strb.advance)  rdPtr <= rdPtr + 1'b1;
  end

  assign fill   = wrBinRd - rdPtr;
  assign bufOut = mem[rdPtr[ADDR_W-1:0]];
  assign txOut  = (strb.en && strb.pathTx)  ? bufOut : txIn;
  assign rxOut  = (strb.en && !strb.pathTx) ? bufOut : rxIn;

  // R5
  recentre_fill_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    strb.recentre |=> (ptr_t'(fill - $past(strb.halfDepth)) <= ptr_t'(2)));
endmodule

// File: rtl/jitter_elastic_store.sv
module jitter_elastic_store
  import jes_pkg::*;
(
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic             cfgWrite,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             txIn,
  input  logic             rxIn,
  output logic             txOut,
  output logic             rxOut,
  output logic             stEmpty,
  output logic             stFull,
  output logic             stHalf,
  output logic             stSlip
);
  strobe_t strb;
  ptr_t    fill;

  jes_ctrl i_ctrl (
    .rdClk(rdClk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgData(cfgData),
    .fill(fill), .strb(strb),
    .stEmpty(stEmpty), .stFull(stFull), .stHalf(stHalf), .stSlip(stSlip)
  );

  jes_datapath i_dp (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strb(strb),
    .txIn(txIn), .rxIn(rxIn), .txOut(txOut), .rxOut(rxOut), .fill(fill)
  );
endmodule

// File: tb/test_jitter_elastic_store.sv
`timescale 1ns/1ps
module test_jitter_elastic_store;
  logic clkW = 1'b0, rdClk = 1'b0, wrGate = 1'b1, rstN = 1'b0;
  logic wrClk;
  logic cfgWrite = 1'b0;
  logic [6:0] cfgData = '0;
  logic txIn = 1'b0, rxIn = 1'b0;
  logic txOut, rxOut, stEmpty, stFull, stHalf, stSlip;
  int rdHalf = 2;
  int cyc = 0;
  int checks = 0, failures = 0;
  bit forceOnes = 1'b0;
  bit ctrBit = 1'b0;
  logic [15:0] lfsrA = 16'hACE1, lfsrB = 16'h3B57;
  logic hTxIn [2048], hRxIn [2048], hTxOut [2048], hRxOut [2048];

  assign wrClk = clkW & wrGate;

  jitter_elastic_store i_jitter_elastic_store (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .cfgWrite(cfgWrite),
    .cfgData(cfgData), .txIn(txIn), .rxIn(rxIn), .txOut(txOut),
    .rxOut(rxOut), .stEmpty(stEmpty), .stFull(stFull), .stHalf(stHalf),
    .stSlip(stSlip)
  );

  initial forever #2 clkW = ~clkW;
  initial begin
    #1;
    forever #(rdHalf) rdClk = ~rdClk;
  end

  // sample outputs and current inputs, then drive the next input bits
  initial forever begin
    @(negedge clkW);
    hTxIn[cyc & 2047]  = txIn;
    hRxIn[cyc & 2047]  = rxIn;
    hTxOut[cyc & 2047] = txOut;
    hRxOut[cyc & 2047] = rxOut;
    lfsrA = {lfsrA[14:0], lfsrA[15] ^ lfsrA[13] ^ lfsrA[12] ^ lfsrA[10]};
    lfsrB = {lfsrB[14:0], lfsrB[15] ^ lfsrB[13] ^ lfsrB[12] ^ lfsrB[10]};
    txIn = forceOnes | lfsrA[0];
    rxIn = forceOnes | lfsrB[0];
    cyc++;
  end

  task automatic check(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(bit en, bit tx, bit ctr, int dep, bit clr);
    @(negedge rdClk);
    cfgData  = {clr, 3'(dep), ctr, tx, en};
    cfgWrite = 1'b1;
    @(negedge rdClk);
    cfgWrite = 1'b0;
  endtask

  task automatic waitW(int n);
    repeat (n) @(negedge clkW);
  endtask

  // smallest delay d with out[k] == in[k-d] over the last 48 samples
  function automatic int findDelay(bit useTx);
    for (int d = 0; d <= 100; d++) begin
      bit ok;
      ok = 1'b1;
      for (int j = 0; j < 48; j++) begin
        int k;
        logic o, i;
        k = cyc - 1 - j;
        o = useTx ? hTxOut[k & 2047] : hRxOut[k & 2047];
        i = useTx ? hTxIn[(k - d) & 2047] : hRxIn[(k - d) & 2047];
        if (o !== i) ok = 1'b0;
      end
      if (ok) return d;
    end
    return -1;
  endfunction

  task automatic finish();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish();
  end

  initial begin
    int d, h, zeros;
    bit sawFull;
    waitW(5);
    rstN = 1'b1;
    @(negedge rdClk);
    // R1
    check("R1 empty", stEmpty == 1'b1, stEmpty, 1);
    check("R1 full/half/slip", {stFull, stHalf, stSlip} == 3'b000,
          {stFull, stHalf, stSlip}, 0);

    // R2: disabled store passes both paths straight through
    waitW(60);
    d = findDelay(1'b1); check("R2 tx bypass", d == 0, d, 0);
    d = findDelay(1'b0); check("R2 rx bypass", d == 0, d, 0);

    cfg(1, 0, ctrBit, 0, 0);
    waitW(200);

    // R4 R5 R11: depth sweep on the receive path, centre bit alternating
    for (int dep = 0; dep < 8; dep++) begin
      ctrBit = ~ctrBit;
      cfg(1, 0, ctrBit, dep, 0);
      waitW(70);
      h = (dep + 1) * 8;
      d = findDelay(1'b0);
      check("R4 R5 rx latency", d >= h && d <= h + 6, d, h);
      d = findDelay(1'b1);
      check("R3 tx passes while rx buffered", d == 0, d, 0);
      @(negedge rdClk);
      check("R11 steady flags", {stHalf, stFull, stEmpty} == 3'b100,
            {stHalf, stFull, stEmpty}, 4);
    end

    // R6: depth 0 written without a recentre keeps depth 128 latency
    cfg(1, 0, ctrBit, 0, 0);
    waitW(70);
    d = findDelay(1'b0);
    check("R6 depth held", d >= 64 && d <= 70, d, 64);
    ctrBit = ~ctrBit;
    cfg(1, 0, ctrBit, 0, 0);
    waitW(70);
    d = findDelay(1'b0);
    check("R6 depth applied at recentre", d >= 8 && d <= 14, d, 8);

    // R3: transmit path
    ctrBit = ~ctrBit;
    cfg(1, 1, ctrBit, 0, 0);
    waitW(70);
    d = findDelay(1'b1); check("R3 tx latency", d >= 8 && d <= 14, d, 8);
    d = findDelay(1'b0); check("R3 rx passes while tx buffered", d == 0, d, 0);
    check("R9 no slip at matched rates", stSlip == 1'b0, stSlip, 0);

    // R7 R8 R9: fill with ones, stop writes, clear, recentre and drain
    ctrBit = ~ctrBit;
    cfg(1, 0, ctrBit, 0, 0);
    forceOnes = 1'b1;
    waitW(300);
    wrGate = 1'b0;
    cfg(1, 0, ctrBit, 0, 1);
    repeat (10) @(negedge rdClk);
    check("R7 flags during clear", {stEmpty, stFull, stSlip} == 3'b100,
          {stEmpty, stFull, stSlip}, 4);
    cfg(1, 0, ctrBit, 0, 0);
    repeat (10) @(negedge rdClk);
    check("R7 idle after clear", {stEmpty, stSlip} == 2'b10, {stEmpty, stSlip}, 2);
    ctrBit = ~ctrBit;
    cfg(1, 0, ctrBit, 0, 0);
    zeros = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge rdClk);
      if (rxOut !== 1'b1) zeros++;
    end
    check("R8 stored bits kept over clear", zeros == 0, zeros, 0);
    check("R9 underflow sets slip", stSlip == 1'b1, stSlip, 1);

    // R10: read clock at half rate overflows the store
    @(negedge clkW);
    wrGate = 1'b1;
    forceOnes = 1'b0;
    cfg(1, 0, ctrBit, 0, 1);
    repeat (5) @(negedge rdClk);
    cfg(1, 0, ctrBit, 0, 0);
    repeat (3) @(negedge rdClk);
    check("R7 clear resets slip", stSlip == 1'b0, stSlip, 0);
    rdHalf = 4;
    ctrBit = ~ctrBit;
    cfg(1, 0, ctrBit, 0, 0);
    sawFull = 1'b0;
    for (int n = 0; n < 200; n++) begin
      @(negedge rdClk);
      if (stFull) sawFull = 1'b1;
    end
    check("R10 full flag seen", sawFull, sawFull, 1);
    check("R10 overflow sets slip", stSlip == 1'b1, stSlip, 1);
    rdHalf = 2;
    finish();
  end
endmodule